// File: doc/BRIEF.md
# Interrupt Controller Register Access Decoder

This block sits in front of an interrupt controller's register file. It turns two kinds of requester traffic into single 32-bit internal register strobes. The first kind is byte-addressed memory-bus accesses into a 4 KiB window. The second kind is 64-bit model-specific-register (MSR) accesses. For each request it decides whether the access is claimed, legal, refused or silently dropped. It then issues the internal read or write strobe at a 16-byte-aligned register offset and returns a one-cycle completion pulse, with a fault or miss flag and the read data.

Both paths share one offset space, in which each register occupies a 16-byte slot. A 64-bit readability mask selects which slots may be read. The MSR path maps number N to offset (N - 0x800) << 4. One MSR number (0x830) carries the 64-bit interrupt command. A write to it becomes two internal writes, upper half first. A read of it becomes two internal reads that are joined into one 64-bit result. The register file answers a read combinationally, in the same cycle that the read strobe is high.

The control is a five-state machine:
- S_IDLE accepts requests.
- S_MEM_RD returns memory read data.
- S_MSR_WR_LO issues the second write of a command store.
- S_MSR_RD_LO collects the low read word.
- S_MSR_RD_HI collects the command-high word.

Transitions:
- S_IDLE goes to S_MEM_RD on a legal memory read.
- S_IDLE goes to S_MSR_WR_LO on a command write.
- S_IDLE goes to S_MSR_RD_LO on a legal MSR read.
- S_MSR_RD_LO goes to S_MSR_RD_HI when the read was to the command number, and otherwise back to S_IDLE.
- Every other state returns to S_IDLE after one cycle.
- Every other request is answered directly from S_IDLE.

Top module: `irqc_acc_decoder`

## Requirements
- R1: A memory access is claimed only when `hw_en` is 1 and `win_base <= mem_addr < win_base + 0x1000`. An unclaimed access completes one cycle after the request with `mem_done` and `mem_miss` high and no strobe.
- R2: A claimed memory write with `mem_len == 4` and window offset bits [3:0] equal to 0 causes exactly one `reg_wr` at offset `off & 0xFF0` with `mem_wdata`. Any other claimed write produces no strobe and no fault. Every strobe offset has bits [3:0] equal to 0.
- R3: A claimed memory read is refused, with `mem_fault` and no strobe, when offset bits [3:0] plus `mem_len` exceed 4.
- R4: On both paths, a read is refused (fault pulse, no strobe) when its offset exceeds 0x3F0, or when bit (offset >> 4) of the mask 0x43FF01FFFFFFE70C is 0.
- R5: A legal memory read issues one `reg_rd` at `off & 0xFF0`. It returns in `mem_rdata` byte k equal to byte (off[1:0] + k) of the register word for k < `mem_len`, and zero for the other bytes.
- R6: MSR numbers 0x800 to 0xBFF are claimed and map to offset (N - 0x800) << 4. A write other than to 0x830 issues one `reg_wr` of data bits [31:0]. Any other number completes with `msr_miss` and no strobe.
- R7: A claimed MSR access while `ext_mode` is 0 completes with `msr_fault` and no strobe.
- R8: An MSR write to 0x830 issues `reg_wr` at 0x310 with bits [63:32], and on the next cycle `reg_wr` at 0x300 with bits [31:0]. `msr_done` goes high with the second write.
- R9: An MSR read of 0x830 reads 0x300 and then 0x310 on consecutive cycles and returns {word at 0x310, word at 0x300}. Any other legal MSR read returns zero in bits [63:32].
- R10: `reg_rd` and `reg_wr` are never high together, and a fault or miss flag appears only with its done pulse. Latency from the request cycle to done is 1 cycle for immediate answers and for ordinary writes, 2 cycles for a command write or an ordinary read, and 3 cycles for a command read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_en | input | 1 | Controller hardware enable; gates memory claims |
| ext_mode | input | 1 | Extended mode; the MSR path faults when it is 0 |
| win_base | input | ADDR_W | Base address of the 4 KiB memory window |
| mem_req | input | 1 | Memory request, one cycle |
| mem_we | input | 1 | Memory request is a write |
| mem_addr | input | ADDR_W | Memory byte address |
| mem_len | input | 4 | Access length in bytes (1 to 8) |
| mem_wdata | input | 32 | Memory write data |
| mem_done | output | 1 | Memory request completion pulse |
| mem_miss | output | 1 | Memory request was not claimed |
| mem_fault | output | 1 | Memory read refused |
| mem_rdata | output | 32 | Memory read data, valid with `mem_done` after a legal read |
| msr_req | input | 1 | MSR request, one cycle |
| msr_we | input | 1 | MSR request is a write |
| msr_num | input | NUM_W | MSR number |
| msr_wdata | input | 64 | MSR write data |
| msr_done | output | 1 | MSR request completion pulse |
| msr_miss | output | 1 | MSR number outside the claimed range |
| msr_fault | output | 1 | MSR access refused |
| msr_rdata | output | 64 | MSR read data, valid with `msr_done` after a legal read |
| reg_rd | output | 1 | Internal register read strobe |
| reg_wr | output | 1 | Internal register write strobe |
| reg_off | output | SPAN_BITS+4 | Internal register byte offset (16-byte aligned) |
| reg_wdata | output | 32 | Internal register write data |
| reg_rdata | input | 32 | Register file read word for `reg_off`, valid while `reg_rd` is high |

## Verification
The assertions take it for granted that a requester raises at most one of `mem_req` and `msr_req` in a cycle, and only while the machine is in S_IDLE. Several properties relate a request cycle to the strobes one cycle later, and they are only meaningful under that discipline. The bench keeps within it by holding each request for exactly one cycle, waiting for the matching done pulse, and then waiting one further cycle before the next request. It also holds `hw_en`, `ext_mode` and `win_base` steady for the whole of each access.

// File: rtl/irqc_acc_pkg.sv
package irqc_acc_pkg;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_MEM_RD    = 3'd1,
        S_MSR_WR_LO = 3'd2,
        S_MSR_RD_LO = 3'd3,
        S_MSR_RD_HI = 3'd4
    } acc_state_t;

    // Highest offset any read may target.
    localparam logic [31:0] TOP_READ_OFF = 32'h3F0;

    function automatic logic slot_ok(input logic [63:0] mask, input logic [31:0] off);
        return (off <= TOP_READ_OFF) && mask[off[9:4]];
    endfunction

    // Align a register word to the requested byte lane and blank unrequested bytes.
    function automatic logic [31:0] shape_read(input logic [31:0] word,
                                               input logic [1:0]  lane,
                                               input logic [3:0]  len);
        logic [31:0] s;
        s = word >> {lane, 3'b000};
        for (int i = 0; i < 4; i++) begin
            if (4'(i) >= len) s[8*i +: 8] = 8'h00;
        end
        return s;
    endfunction

endpackage

// File: rtl/irqc_mem_decode.sv
module irqc_mem_decode #(
    parameter int          ADDR_W    = 32,
    parameter int          WIN_BITS  = 12,
    parameter int          OFF_W     = 14,
    parameter logic [63:0] SLOT_MASK = 64'h43FF01FFFFFFE70C
) (
    input  logic              hw_en,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        len,
    output logic              claim,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic [OFF_W-1:0]  reg_off,
    output logic [1:0]        lane
);
    import irqc_acc_pkg::*;

    localparam logic [ADDR_W-1:0] WIN_SIZE = ADDR_W'(1) << WIN_BITS;

    logic [ADDR_W-1:0]   diff;
    logic [WIN_BITS-1:0] off;
    logic [4:0]          span_end;

    always_comb begin
        diff     = addr - win_base;
        off      = diff[WIN_BITS-1:0];
        claim    = hw_en && (addr >= win_base) && (diff < WIN_SIZE);
        span_end = {1'b0, off[3:0]} + {1'b0, len};
        rd_ok    = (span_end <= 5'd4) && slot_ok(SLOT_MASK, 32'(off));
        wr_ok    = (len == 4'd4) && (off[3:0] == 4'd0);
        reg_off  = OFF_W'({off[WIN_BITS-1:4], 4'b0000});
        lane     = off[1:0];
    end

endmodule

// File: rtl/irqc_msr_decode.sv
module irqc_msr_decode #(
    parameter int                NUM_W     = 32,
    parameter int                SPAN_BITS = 10,
    parameter logic [NUM_W-1:0]  MSR_BASE  = 'h800,
    parameter logic [NUM_W-1:0]  CMD_NUM   = 'h830,
    parameter logic [63:0]       SLOT_MASK = 64'h43FF01FFFFFFE70C,
    localparam int               OFF_W     = SPAN_BITS + 4
) (
    input  logic [NUM_W-1:0] num,
    output logic             claim,
    output logic             is_cmd,
    output logic             rd_ok,
    output logic [OFF_W-1:0] reg_off
);
    import irqc_acc_pkg::*;

    localparam logic [NUM_W-1:0] SPAN = NUM_W'(1) << SPAN_BITS;

    logic [NUM_W-1:0] rel;

    always_comb begin
        rel     = num - MSR_BASE;
        claim   = (num >= MSR_BASE) && (rel < SPAN);
        is_cmd  = (num == CMD_NUM);
        reg_off = {rel[SPAN_BITS-1:0], 4'b0000};
        rd_ok   = slot_ok(SLOT_MASK, 32'(reg_off));
    end

endmodule

// File: rtl/irqc_acc_fsm.sv
module irqc_acc_fsm #(
    parameter int                OFF_W      = 14,
    parameter logic [OFF_W-1:0]  CMD_LO_OFF = 'h300,
    parameter logic [OFF_W-1:0]  CMD_HI_OFF = 'h310,
    parameter logic [63:0]       SLOT_MASK  = 64'h43FF01FFFFFFE70C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic             mem_req,
    input  logic             mem_we,
    input  logic [3:0]       mem_len,
    input  logic [31:0]      mem_wdata,
    input  logic             m_claim,
    input  logic             m_wr_ok,
    input  logic             m_rd_ok,
    input  logic [OFF_W-1:0] m_off,
    input  logic [1:0]       m_lane,
    input  logic             msr_req,
    input  logic             msr_we,
    input  logic [63:0]      msr_wdata,
    input  logic             s_claim,
    input  logic             s_is_cmd,
    input  logic             s_rd_ok,
    input  logic [OFF_W-1:0] s_off,
    input  logic [31:0]      reg_rdata,
    output logic             mem_done,
    output logic             mem_miss,
    output logic             mem_fault,
    output logic [31:0]      mem_rdata,
    output logic             msr_done,
    output logic             msr_miss,
    output logic             msr_fault,
    output logic [63:0]      msr_rdata,
    output logic             reg_rd,
    output logic             reg_wr,
    output logic [OFF_W-1:0] reg_off,
    output logic [31:0]      reg_wdata
);
    import irqc_acc_pkg::*;

    acc_state_t  state, state_nx;
    logic [1:0]  lane_q;
    logic [3:0]  len_q;
    logic [31:0] lo_q;
    logic        cmd_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (mem_req) begin
                    if (m_claim && !mem_we && m_rd_ok) state_nx = S_MEM_RD;
                end else if (msr_req && s_claim && ext_mode) begin
                    if (msr_we && s_is_cmd)   state_nx = S_MSR_WR_LO;
                    else if (!msr_we && s_rd_ok) state_nx = S_MSR_RD_LO;
                end
            end
            S_MEM_RD:    state_nx = S_IDLE;
            S_MSR_WR_LO: state_nx = S_IDLE;
            S_MSR_RD_LO: state_nx = cmd_q ? S_MSR_RD_HI : S_IDLE;
            S_MSR_RD_HI: state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // Registered outputs and per-request holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_done  <= 1'b0;
            mem_miss  <= 1'b0;
            mem_fault <= 1'b0;
            mem_rdata <= '0;
            msr_done  <= 1'b0;
            msr_miss  <= 1'b0;
            msr_fault <= 1'b0;
            msr_rdata <= '0;
            reg_rd    <= 1'b0;
            reg_wr    <= 1'b0;
            reg_off   <= '0;
            reg_wdata <= '0;
            lane_q    <= '0;
            len_q     <= '0;
            lo_q      <= '0;
            cmd_q     <= 1'b0;
        end else begin
            mem_done  <= 1'b0;
            mem_miss  <= 1'b0;
            mem_fault <= 1'b0;
            msr_done  <= 1'b0;
            msr_miss  <= 1'b0;
            msr_fault <= 1'b0;
            reg_rd    <= 1'b0;
            reg_wr    <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (mem_req) begin
                        lane_q <= m_lane;
                        len_q  <= mem_len;
                        if (!m_claim) begin
                            mem_done <= 1'b1;
                            mem_miss <= 1'b1;
                        end else if (mem_we) begin
                            mem_done <= 1'b1;
                            if (m_wr_ok) begin
                                reg_wr    <= 1'b1;
                                reg_off   <= m_off;
                                reg_wdata <= mem_wdata;
                            end
                        end else if (m_rd_ok) begin
                            reg_rd  <= 1'b1;
                            reg_off <= m_off;
                        end else begin
                            mem_done  <= 1'b1;
                            mem_fault <= 1'b1;
                        end
                    end else if (msr_req) begin
                        if (!s_claim) begin
                            msr_done <= 1'b1;
                            msr_miss <= 1'b1;
                        end else if (!ext_mode) begin
                            msr_done  <= 1'b1;
                            msr_fault <= 1'b1;
                        end else if (msr_we) begin
                            reg_wr <= 1'b1;
                            if (s_is_cmd) begin
                                reg_off   <= CMD_HI_OFF;
                                reg_wdata <= msr_wdata[63:32];
                                lo_q      <= msr_wdata[31:0];
                            end else begin
                                reg_off   <= s_off;
                                reg_wdata <= msr_wdata[31:0];
                                msr_done  <= 1'b1;
                            end
                        end else if (s_rd_ok) begin
                            reg_rd  <= 1'b1;
                            reg_off <= s_off;
                            cmd_q   <= s_is_cmd;
                        end else begin
                            msr_done  <= 1'b1;
                            msr_fault <= 1'b1;
                        end
                    end
                end
                S_MEM_RD: begin
                    mem_done  <= 1'b1;
                    mem_rdata <= shape_read(reg_rdata, lane_q, len_q);
                end
                S_MSR_WR_LO: begin
                    reg_wr    <= 1'b1;
                    reg_off   <= CMD_LO_OFF;
                    reg_wdata <= lo_q;
                    msr_done  <= 1'b1;
                end
                S_MSR_RD_LO: begin
                    if (cmd_q) begin
                        lo_q    <= reg_rdata;
                        reg_rd  <= 1'b1;
                        reg_off <= CMD_HI_OFF;
                    end else begin
                        msr_done  <= 1'b1;
                        msr_rdata <= {32'h0, reg_rdata};
                    end
                end
                S_MSR_RD_HI: begin
                    msr_done  <= 1'b1;
                    msr_rdata <= {reg_rdata, lo_q};
                end
                default: ;
            endcase
        end
    end

    // Input discipline taken for granted by the other properties (R10)
    p_req_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || msr_req) |-> (state == S_IDLE && !(mem_req && msr_req)));

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    p_mem_flag_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_fault || mem_miss) |-> mem_done);

    p_msr_flag_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_fault || msr_miss) |-> msr_done);

    p_off_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd || reg_wr) |-> (reg_off[3:0] == 4'd0));

    p_rd_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> slot_ok(SLOT_MASK, 32'(reg_off)));

    p_cmd_wr_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MSR_WR_LO) |-> (reg_wr && reg_off == CMD_HI_OFF && !msr_done));

    p_cmd_wr_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MSR_WR_LO) |=> (reg_wr && reg_off == CMD_LO_OFF && msr_done));

    p_cmd_rd_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MSR_RD_HI) |-> (reg_rd && reg_off == CMD_HI_OFF));

endmodule

// File: rtl/irqc_acc_decoder.sv
module irqc_acc_decoder #(
    parameter int                ADDR_W    = 32,
    parameter int                WIN_BITS  = 12,
    parameter int                NUM_W     = 32,
    parameter int                SPAN_BITS = 10,
    parameter logic [NUM_W-1:0]  MSR_BASE  = 'h800,
    parameter logic [NUM_W-1:0]  CMD_NUM   = 'h830,
    parameter logic [63:0]       SLOT_MASK = 64'h43FF01FFFFFFE70C,
    localparam int               OFF_W     = SPAN_BITS + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic              ext_mode,
    input  logic [ADDR_W-1:0] win_base,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [3:0]        mem_len,
    input  logic [31:0]       mem_wdata,
    output logic              mem_done,
    output logic              mem_miss,
    output logic              mem_fault,
    output logic [31:0]       mem_rdata,
    input  logic              msr_req,
    input  logic              msr_we,
    input  logic [NUM_W-1:0]  msr_num,
    input  logic [63:0]       msr_wdata,
    output logic              msr_done,
    output logic              msr_miss,
    output logic              msr_fault,
    output logic [63:0]       msr_rdata,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [OFF_W-1:0]  reg_off,
    output logic [31:0]       reg_wdata,
    input  logic [31:0]       reg_rdata
);

    localparam logic [OFF_W-1:0] CMD_LO_OFF = OFF_W'((CMD_NUM - MSR_BASE) << 4);
    localparam logic [OFF_W-1:0] CMD_HI_OFF = CMD_LO_OFF + OFF_W'(16);

    logic             m_claim, m_wr_ok, m_rd_ok;
    logic [OFF_W-1:0] m_off;
    logic [1:0]       m_lane;
    logic             s_claim, s_is_cmd, s_rd_ok;
    logic [OFF_W-1:0] s_off;
    logic [3:0]       a_nib;

    assign a_nib = mem_addr[3:0] - win_base[3:0];

    irqc_mem_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .OFF_W    (OFF_W),
        .SLOT_MASK(SLOT_MASK)
    ) u_mem_dec (
        .hw_en   (hw_en),
        .win_base(win_base),
        .addr    (mem_addr),
        .len     (mem_len),
        .claim   (m_claim),
        .wr_ok   (m_wr_ok),
        .rd_ok   (m_rd_ok),
        .reg_off (m_off),
        .lane    (m_lane)
    );

    irqc_msr_decode #(
        .NUM_W    (NUM_W),
        .SPAN_BITS(SPAN_BITS),
        .MSR_BASE (MSR_BASE),
        .CMD_NUM  (CMD_NUM),
        .SLOT_MASK(SLOT_MASK)
    ) u_msr_dec (
        .num    (msr_num),
        .claim  (s_claim),
        .is_cmd (s_is_cmd),
        .rd_ok  (s_rd_ok),
        .reg_off(s_off)
    );

    irqc_acc_fsm #(
        .OFF_W     (OFF_W),
        .CMD_LO_OFF(CMD_LO_OFF),
        .CMD_HI_OFF(CMD_HI_OFF),
        .SLOT_MASK (SLOT_MASK)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_mode (ext_mode),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_len  (mem_len),
        .mem_wdata(mem_wdata),
        .m_claim  (m_claim),
        .m_wr_ok  (m_wr_ok),
        .m_rd_ok  (m_rd_ok),
        .m_off    (m_off),
        .m_lane   (m_lane),
        .msr_req  (msr_req),
        .msr_we   (msr_we),
        .msr_wdata(msr_wdata),
        .s_claim  (s_claim),
        .s_is_cmd (s_is_cmd),
        .s_rd_ok  (s_rd_ok),
        .s_off    (s_off),
        .reg_rdata(reg_rdata),
        .mem_done (mem_done),
        .mem_miss (mem_miss),
        .mem_fault(mem_fault),
        .mem_rdata(mem_rdata),
        .msr_done (msr_done),
        .msr_miss (msr_miss),
        .msr_fault(msr_fault),
        .msr_rdata(msr_rdata),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .reg_off  (reg_off),
        .reg_wdata(reg_wdata)
    );

    p_mem_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !m_claim) |=> (mem_done && mem_miss && !reg_rd && !reg_wr));

    p_wr_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && m_claim && mem_we && !(mem_len == 4'd4 && a_nib == 4'd0))
        |=> (mem_done && !mem_fault && !reg_wr && !reg_rd));

    p_rd_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && m_claim && !mem_we && (({1'b0, a_nib} + {1'b0, mem_len}) > 5'd4))
        |=> (mem_fault && !reg_rd));

    p_msr_noext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_req && !mem_req && s_claim && !ext_mode)
        |=> (msr_done && msr_fault && !reg_rd && !reg_wr));

endmodule

// File: tb/irqc_acc_decoder_tb.sv
module irqc_acc_decoder_tb;

    localparam logic [63:0] MASK = 64'h43FF01FFFFFFE70C;
    localparam logic [31:0] BASE = 32'hFEE0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_en = 1'b1, ext_mode = 1'b1;
    logic [31:0] win_base = BASE;
    logic        mem_req = 1'b0, mem_we = 1'b0;
    logic [31:0] mem_addr = '0;
    logic [3:0]  mem_len = '0;
    logic [31:0] mem_wdata = '0;
    logic        mem_done, mem_miss, mem_fault;
    logic [31:0] mem_rdata;
    logic        msr_req = 1'b0, msr_we = 1'b0;
    logic [31:0] msr_num = '0;
    logic [63:0] msr_wdata = '0;
    logic        msr_done, msr_miss, msr_fault;
    logic [63:0] msr_rdata;
    logic        reg_rd, reg_wr;
    logic [13:0] reg_off;
    logic [31:0] reg_wdata, reg_rdata;

    int n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    function automatic logic [31:0] pat(input int slot);
        return 32'h9E37_79B9 ^ (32'(slot) * 32'h0103_0507);
    endfunction

    assign reg_rdata = pat(int'(reg_off[13:4]));

    irqc_acc_decoder u_dut (.*);

    // Strobe log, sampled mid-cycle
    int          lg_n = 0;
    logic        lg_wr  [8];
    logic [13:0] lg_off [8];
    logic [31:0] lg_dat [8];
    always @(negedge clk) begin
        if (rst_n && (reg_rd || reg_wr) && lg_n < 8) begin
            lg_wr[lg_n]  = reg_wr;
            lg_off[lg_n] = reg_off;
            lg_dat[lg_n] = reg_wdata;
            lg_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit readable(input int off);
        return (off <= 'h3F0) && MASK[off >> 4];
    endfunction

    // Compare the strobe log against up to two expected strobes
    task automatic chk_log(input string tag, input int en, input bit ew0, input int eo0,
                           input logic [31:0] ed0, input bit ew1, input int eo1, input logic [31:0] ed1);
        chk(lg_n == en, {tag, " strobe count"}, 64'(lg_n), 64'(en));
        if (lg_n == en && en >= 1) begin
            chk(lg_wr[0] == ew0 && int'(lg_off[0]) == eo0, {tag, " strobe0 kind/off"},
                {48'(lg_wr[0]), 16'(lg_off[0])}, {48'(ew0), 16'(eo0)});
            if (ew0) chk(lg_dat[0] == ed0, {tag, " strobe0 data"}, 64'(lg_dat[0]), 64'(ed0));
        end
        if (lg_n == en && en >= 2) begin
            chk(lg_wr[1] == ew1 && int'(lg_off[1]) == eo1, {tag, " strobe1 kind/off"},
                {48'(lg_wr[1]), 16'(lg_off[1])}, {48'(ew1), 16'(eo1)});
            if (ew1) chk(lg_dat[1] == ed1, {tag, " strobe1 data"}, 64'(lg_dat[1]), 64'(ed1));
        end
    endtask

    task automatic run_mem(input bit we, input logic [31:0] addr, input int len, input logic [31:0] wd);
        int lat;
        int e_lat, e_n;
        bit e_miss, e_fault, claim;
        int off;
        logic [31:0] w, e_rd, g_rd;
        bit g_miss, g_fault;
        string tag;
        claim = hw_en && (addr >= win_base) && ((addr - win_base) < 32'h1000);
        off = int'(addr - win_base);
        e_miss = 0; e_fault = 0; e_n = 0; e_lat = 1; e_rd = '0;
        if (!claim) begin
            e_miss = 1; tag = "R1";
        end else if (we) begin
            tag = "R2";
            if (len == 4 && off % 16 == 0) e_n = 1;
        end else if ((off % 16) + len > 4) begin
            e_fault = 1; tag = "R3";
        end else if (!readable(off)) begin
            e_fault = 1; tag = "R4";
        end else begin
            tag = "R5"; e_n = 1; e_lat = 2;
            w = pat(off >> 4);
            for (int b = 0; b < len; b++) e_rd[8*b +: 8] = w[8*((off % 4) + b) +: 8];
        end
        @(negedge clk);
        lg_n = 0;
        mem_req = 1; mem_we = we; mem_addr = addr; mem_len = 4'(len); mem_wdata = wd;
        @(negedge clk);
        mem_req = 0;
        lat = 1;
        while (!mem_done && lat < 20) begin @(negedge clk); lat++; end
        g_miss = mem_miss; g_fault = mem_fault; g_rd = mem_rdata;
        @(negedge clk);
        chk(lat == e_lat, {tag, " R10 latency"}, 64'(lat), 64'(e_lat));
        chk(g_miss == e_miss && g_fault == e_fault, {tag, " miss/fault"},
            {32'(g_miss), 32'(g_fault)}, {32'(e_miss), 32'(e_fault)});
        chk_log(tag, e_n, we, off & 'hFF0, wd, 0, 0, 0);
        if (e_n == 1 && !we) chk(g_rd == e_rd, {tag, " read data"}, 64'(g_rd), 64'(e_rd));
    endtask

    task automatic run_msr(input bit we, input logic [31:0] num, input logic [63:0] wd);
        int lat, e_lat, e_n, off;
        bit e_miss, e_fault, ew0, ew1;
        int eo0, eo1;
        logic [31:0] ed0, ed1;
        logic [63:0] e_rd, g_rd;
        bit g_miss, g_fault;
        string tag;
        off = int'(num - 32'h800) << 4;
        e_miss = 0; e_fault = 0; e_n = 0; e_lat = 1; e_rd = '0;
        ew0 = we; ew1 = we; eo0 = 0; eo1 = 0; ed0 = '0; ed1 = '0;
        tag = "R6";
        if (num < 32'h800 || num >= 32'hC00) begin
            e_miss = 1;
        end else if (!ext_mode) begin
            e_fault = 1; tag = "R7";
        end else if (we && num == 32'h830) begin
            tag = "R8"; e_n = 2; e_lat = 2;
            eo0 = 'h310; ed0 = wd[63:32]; eo1 = 'h300; ed1 = wd[31:0];
        end else if (we) begin
            e_n = 1; eo0 = off; ed0 = wd[31:0];
        end else if (!readable(off)) begin
            e_fault = 1; tag = "R4";
        end else if (num == 32'h830) begin
            tag = "R9"; e_n = 2; e_lat = 3; eo0 = 'h300; eo1 = 'h310;
            e_rd = {pat('h31), pat('h30)};
        end else begin
            tag = "R9"; e_n = 1; e_lat = 2; eo0 = off;
            e_rd = {32'h0, pat(off >> 4)};
        end
        @(negedge clk);
        lg_n = 0;
        msr_req = 1; msr_we = we; msr_num = num; msr_wdata = wd;
        @(negedge clk);
        msr_req = 0;
        lat = 1;
        while (!msr_done && lat < 20) begin @(negedge clk); lat++; end
        g_miss = msr_miss; g_fault = msr_fault; g_rd = msr_rdata;
        @(negedge clk);
        chk(lat == e_lat, {tag, " R10 latency"}, 64'(lat), 64'(e_lat));
        chk(g_miss == e_miss && g_fault == e_fault, {tag, " miss/fault"},
            {32'(g_miss), 32'(g_fault)}, {32'(e_miss), 32'(e_fault)});
        chk_log(tag, e_n, ew0, eo0, ed0, ew1, eo1, ed1);
        if (e_n >= 1 && !we) chk(g_rd == e_rd, {tag, " read data"}, g_rd, e_rd);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!mem_done && !msr_done && !reg_rd && !reg_wr && !mem_fault && !msr_fault,
            "R10 reset state", {60'h0, mem_done, msr_done, reg_rd, reg_wr}, 64'h0);

        // R4 slot sweep through the memory path, including past 0x3F0
        for (int s = 0; s <= 'h41; s++) run_mem(0, BASE + 32'(s * 16), 4, '0);
        // R3/R5 alignment x length sweep on a readable slot
        for (int n = 0; n < 16; n++)
            for (int l = 1; l <= 8; l++) run_mem(0, BASE + 32'h20 + 32'(n), l, '0);
        // R2 write sweep
        for (int n = 0; n < 16; n++)
            for (int l = 1; l <= 8; l++) run_mem(1, BASE + 32'h80 + 32'(n), l, 32'hC0DE_0000 + 32'(n * 16 + l));
        // R1 window edges and enable
        run_mem(0, BASE - 4, 4, '0);
        run_mem(1, BASE + 32'hFF0, 4, 32'h1234_5678);
        run_mem(0, BASE + 32'hFFC, 4, '0);
        run_mem(1, BASE + 32'h1000, 4, 32'h1);
        hw_en = 0;
        run_mem(0, BASE + 32'h20, 4, '0);
        run_mem(1, BASE + 32'h80, 4, 32'h2);
        hw_en = 1;

        // R4/R6/R9 MSR read sweep
        for (int k = 'h800; k <= 'h841; k++) run_msr(0, 32'(k), '0);
        run_msr(0, 32'hBFF, '0);
        // R6 range edges and plain writes
        run_msr(0, 32'h7FF, '0);
        run_msr(0, 32'hC00, '0);
        run_msr(1, 32'h7FF, 64'h5);
        run_msr(1, 32'h808, 64'hFFFF_FFFF_AAAA_5555);
        run_msr(1, 32'hBFF, 64'h0123_4567_89AB_CDEF);
        // R8/R9 command register
        run_msr(1, 32'h830, 64'hDEAD_BEEF_0000_40FE);
        run_msr(1, 32'h830, 64'h0000_0003_000C_4031);
        run_msr(0, 32'h830, '0);
        // R7 extended mode off
        ext_mode = 0;
        run_msr(0, 32'h802, '0);
        run_msr(1, 32'h830, 64'h1111_2222_3333_4444);
        run_msr(1, 32'h808, 64'h7);
        run_msr(0, 32'h7FF, '0);
        ext_mode = 1;
        run_msr(0, 32'h808, '0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule